// File: doc/BRIEF.md
# Two-Hit Pixel Digital Front-End

This block is the digital logic inside one pixel of a monolithic sensor array. It works in two phases. While the acquisition input is high, which covers a bunch train, the pixel watches a one-cycle hit pulse from its discriminator. A 5-bit time stamp bus is shared by all pixels. On the first hit the pixel stores the value on that bus in one slot, and on the second hit it stores the value in a second slot. Any hit after that is dropped. A single mask flip-flop sits on its own serial chain with its own clock. When that flip-flop holds a one, the pixel is silenced.

While the acquisition input is low, which covers the gap between trains, the pixel is one link in a token chain. If it holds no stored hit, the token passes straight through it with no clock delay. If it has stored hits and holds the token, it presents one hit per cell clock, oldest first. For each hit it raises its row and column select lines and puts the stored stamp on its stamp output. The stamp output is forced to zero at all other times, so a wired-OR bus shared by many pixels carries only the stamp of the active pixel. The token moves on in the same cycle that the last stored hit is presented.

Top module: `pix_twohit_cell`

## Requirements
- R1: A synchronous active-high `rst` clears both hit slots and both stored stamps, and drives `row_sel`, `col_sel` and `ts_out` low. After reset an empty pixel shows `tok_out` equal to `tok_in`.
- R2: When `acq`=1, `hit`=1 and the pixel is not killed, the first hit captures `ts_bus` at that rising `clk` edge. That stamp is the one presented first in readout.
- R3: A second qualifying hit captures `ts_bus` at its own edge. That stamp is presented second in readout.
- R4: Once two hits are stored, further hits during acquisition have no effect on the slots or on the readout.
- R5: The kill flip-flop loads `mask_in` on the rising edge of `mask_clk`, and `mask_out` shows its value. `rst` leaves it unchanged. While it holds 1, every hit is ignored.
- R6: Hits arriving while `acq`=0 are ignored.
- R7: With no stored hit, `tok_out` follows `tok_in` combinationally.
- R8: In readout (`acq`=0), a pixel that has a stored hit and sees `tok_in`=1 presents one stored hit at the next rising `clk` edge. For that one cycle it holds `row_sel`=`col_sel`=1 and sets `ts_out` to the stamp. It then clears that slot. The first hit is presented before the second.
- R9: `tok_out` stays 0 while any hit is stored. It rises in the cycle where the last stored hit is presented, provided `tok_in`=1.
- R10: `ts_out` is all zeros whenever `row_sel` is 0. Dropping `tok_in` pauses readout, and no hit is presented while the token is absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst | input | 1 | Synchronous active-high clear of hit state and readout outputs |
| acq | input | 1 | 1 = acquisition phase, 0 = readout phase |
| hit | input | 1 | Discriminator hit pulse, synchronous to `clk` |
| ts_bus | input | 5 | Broadcast time stamp |
| mask_clk | input | 1 | Clock of the kill-mask chain |
| mask_in | input | 1 | Serial kill-mask input |
| mask_out | output | 1 | Serial kill-mask output (kill flip-flop value) |
| tok_in | input | 1 | Readout token from the previous pixel |
| tok_out | output | 1 | Readout token to the next pixel |
| row_sel | output | 1 | Row select while a hit is presented |
| col_sel | output | 1 | Column select while a hit is presented |
| ts_out | output | 5 | Stored stamp of the presented hit, zero otherwise |

## Verification
The assertions assume the following:
- `acq` changes only between complete phases.
- The kill chain is shifted only while the pixel is idle, so `mask_clk` activity never lands near a `clk` edge in which a hit is taken.
- `hit` is a clean pulse synchronous to the cell clock.

The bench stays within these limits. It loads the mask with the cell clock low and before acquisition starts, and it changes every input on the falling edge of `clk`. The stimulus is a full sweep over:
- zero to three hits,
- mask on and mask off,
- a clear in the middle of the sequence or no clear.

Each run ends with a readout phase that contains a stray hit and a token that is withheld for one cycle.

// File: rtl/pix_pkg.sv
package pix_pkg;

    // Default stamp width and number of hit slots per pixel
    localparam int unsigned PIX_TS_W     = 5;
    localparam int unsigned PIX_NSLOT    = 2;
    // Widest slot vector the helpers below accept
    localparam int unsigned PIX_MAX_SLOT = 8;

    typedef enum logic {
        PH_READOUT = 1'b0,
        PH_ACQUIRE = 1'b1
    } phase_e;

    // Readout beat presented on the pixel outputs
    typedef struct packed {
        logic                sel;
        logic [PIX_TS_W-1:0] ts;
    } beat_t;

    // Keep only the lowest set bit (slot priority: lowest index first)
    function automatic logic [PIX_MAX_SLOT-1:0] low_one(input logic [PIX_MAX_SLOT-1:0] v);
        return v & (~v + PIX_MAX_SLOT'(1));
    endfunction

endpackage

// File: rtl/pix_kill_mask.sv
module pix_kill_mask (
    input  logic mask_clk,
    input  logic mask_in,
    output logic kill,
    output logic mask_out
);

    logic kill_q;

    // Not touched by the hit-state reset: the mask survives a clear
    always_ff @(posedge mask_clk) begin
        kill_q <= mask_in;
    end

    assign kill     = kill_q;
    assign mask_out = kill_q;

endmodule

// File: rtl/pix_hit_store.sv
module pix_hit_store
    import pix_pkg::*;
#(
    parameter int unsigned TS_W   = PIX_TS_W,
    parameter int unsigned N_SLOT = PIX_NSLOT
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   take,
    input  logic [TS_W-1:0]        ts_in,
    input  logic [N_SLOT-1:0]      clr_oh,
    output logic [N_SLOT-1:0]      occ,
    output logic [N_SLOT*TS_W-1:0] ts_flat
);

    localparam int unsigned PAD = PIX_MAX_SLOT - N_SLOT;

    logic [N_SLOT-1:0]       fill_oh;
    logic [PIX_MAX_SLOT-1:0] free_wide;
    logic [PIX_MAX_SLOT-1:0] fill_wide;

    // Lowest free slot is filled next; zero when all slots are taken
    assign free_wide = {{PAD{1'b0}}, ~occ};
    assign fill_wide = low_one(free_wide);
    assign fill_oh   = fill_wide[N_SLOT-1:0];

    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
        logic            occ_q;
        logic [TS_W-1:0] ts_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                occ_q <= 1'b0;
                ts_q  <= '0;
            end else if (take && fill_oh[s]) begin
                occ_q <= 1'b1;
                ts_q  <= ts_in;
            end else if (clr_oh[s]) begin
                occ_q <= 1'b0;
            end
        end

        assign occ[s]                  = occ_q;
        assign ts_flat[s*TS_W +: TS_W] = ts_q;
    end

endmodule

// File: rtl/pix_read_ctl.sv
module pix_read_ctl
    import pix_pkg::*;
#(
    parameter int unsigned TS_W   = PIX_TS_W,
    parameter int unsigned N_SLOT = PIX_NSLOT
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   readout,
    input  logic                   tok_in,
    input  logic [N_SLOT-1:0]      occ,
    input  logic [N_SLOT*TS_W-1:0] ts_flat,
    output logic [N_SLOT-1:0]      clr_oh,
    output logic                   tok_out,
    output logic                   sel,
    output logic [TS_W-1:0]        ts_out
);

    localparam int unsigned PAD = PIX_MAX_SLOT - N_SLOT;

    logic                    pending;
    logic                    grant;
    logic [PIX_MAX_SLOT-1:0] rd_wide;
    logic [N_SLOT-1:0]       rd_oh;
    logic [TS_W-1:0]         pick;
    logic                    sel_q;
    logic [TS_W-1:0]         ts_q;

    assign pending = |occ;
    // Empty pixel: token passes through with no clock delay
    assign tok_out = tok_in & ~pending;
    assign grant   = readout & tok_in & pending;

    // Oldest stored hit sits in the lowest occupied slot
    assign rd_wide = low_one({{PAD{1'b0}}, occ});
    assign rd_oh   = rd_wide[N_SLOT-1:0];
    assign clr_oh  = grant ? rd_oh : '0;

    always_comb begin
        pick = '0;
        for (int s = 0; s < N_SLOT; s++) begin
            pick = pick | (ts_flat[s*TS_W +: TS_W] & {TS_W{rd_oh[s]}});
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 1'b0;
            ts_q  <= '0;
        end else begin
            sel_q <= grant;
            ts_q  <= grant ? pick : '0;
        end
    end

    // AND gating keeps the shared stamp bus at zero unless selected
    assign sel    = sel_q;
    assign ts_out = ts_q & {TS_W{sel_q}};

endmodule

// File: rtl/pix_twohit_cell.sv
module pix_twohit_cell
    import pix_pkg::*;
#(
    parameter int unsigned TS_W   = PIX_TS_W,
    parameter int unsigned N_SLOT = PIX_NSLOT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            acq,
    input  logic            hit,
    input  logic [TS_W-1:0] ts_bus,
    input  logic            mask_clk,
    input  logic            mask_in,
    output logic            mask_out,
    input  logic            tok_in,
    output logic            tok_out,
    output logic            row_sel,
    output logic            col_sel,
    output logic [TS_W-1:0] ts_out
);

    phase_e                  ph;
    logic                    kill;
    logic                    take;
    logic [N_SLOT-1:0]       occ;
    logic [N_SLOT-1:0]       clr_oh;
    logic [N_SLOT*TS_W-1:0]  ts_flat;
    logic                    sel;

    assign ph   = acq ? PH_ACQUIRE : PH_READOUT;
    assign take = (ph == PH_ACQUIRE) & hit & ~kill;

    pix_kill_mask u_mask (
        .mask_clk (mask_clk),
        .mask_in  (mask_in),
        .kill     (kill),
        .mask_out (mask_out)
    );

    pix_hit_store #(.TS_W(TS_W), .N_SLOT(N_SLOT)) u_store (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .ts_in   (ts_bus),
        .clr_oh  (clr_oh),
        .occ     (occ),
        .ts_flat (ts_flat)
    );

    pix_read_ctl #(.TS_W(TS_W), .N_SLOT(N_SLOT)) u_read (
        .clk     (clk),
        .rst     (rst),
        .readout (ph == PH_READOUT),
        .tok_in  (tok_in),
        .occ     (occ),
        .ts_flat (ts_flat),
        .clr_oh  (clr_oh),
        .tok_out (tok_out),
        .sel     (sel),
        .ts_out  (ts_out)
    );

    assign row_sel = sel;
    assign col_sel = sel;

endmodule

// File: rtl/pix_twohit_cell_chk.sv
module pix_twohit_cell_chk #(
    parameter int unsigned TS_W   = 5,
    parameter int unsigned N_SLOT = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              acq,
    input logic              hit,
    input logic              tok_in,
    input logic              tok_out,
    input logic              row_sel,
    input logic [TS_W-1:0]   ts_out,
    input logic [N_SLOT-1:0] occ,
    input logic              kill
);

    // R7
    tok_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (occ == '0) |-> (tok_out == tok_in));

    // R9
    tok_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (occ != '0) |-> !tok_out);

    // R5
    kill_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (acq && hit && kill) |=> $stable(occ));

    // R6
    readout_nofill_chk: assert property (@(posedge clk) disable iff (rst)
        !acq |=> ((occ & ~$past(occ)) == '0));

    // R4
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (acq && (&occ)) |=> (&occ));

    // R8
    sel_token_chk: assert property (@(posedge clk) disable iff (rst)
        row_sel |-> ($past(tok_in) && !$past(acq)));

    // R8
    read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        row_sel |-> ($countones(occ) < $countones($past(occ))));

    // R10
    bus_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !row_sel |-> (ts_out == '0));

endmodule

bind pix_twohit_cell pix_twohit_cell_chk #(.TS_W(TS_W), .N_SLOT(N_SLOT)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .acq     (acq),
    .hit     (hit),
    .tok_in  (tok_in),
    .tok_out (tok_out),
    .row_sel (row_sel),
    .ts_out  (ts_out),
    .occ     (occ),
    .kill    (kill)
);

// File: tb/pix_twohit_cell_tb_top.sv
module pix_twohit_cell_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       acq = 1'b0;
    logic       hit = 1'b0;
    logic [4:0] ts_bus = '0;
    logic       mask_clk = 1'b0;
    logic       mask_in = 1'b0;
    logic       mask_out;
    logic       tok_in = 1'b0;
    logic       tok_out;
    logic       row_sel;
    logic       col_sel;
    logic [4:0] ts_out;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    pix_twohit_cell dut_i (
        .clk      (clk),
        .rst      (rst),
        .acq      (acq),
        .hit      (hit),
        .ts_bus   (ts_bus),
        .mask_clk (mask_clk),
        .mask_in  (mask_in),
        .mask_out (mask_out),
        .tok_in   (tok_in),
        .tok_out  (tok_out),
        .row_sel  (row_sel),
        .col_sel  (col_sel),
        .ts_out   (ts_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] stamp(input int base, input int i);
        return 5'((base + 7 * i) % 32);
    endfunction

    initial begin
        int cs = 0;
        for (int nh = 0; nh < 4; nh++) begin
            for (int kl = 0; kl < 2; kl++) begin
                for (int wp = 0; wp < 2; wp++) begin
                    int base;
                    int nexp;
                    logic [4:0] exp_ts [2];
                    base = 3 + 5 * cs;
                    cs++;
                    // reset
                    @(negedge clk);
                    rst = 1'b1; acq = 1'b0; hit = 1'b0; tok_in = 1'b1;
                    @(negedge clk);
                    @(negedge clk);
                    rst = 1'b0;
                    #1;
                    chk("R1 row_sel after reset", row_sel, 0);
                    chk("R1 ts_out after reset", ts_out, 0);
                    chk("R1 tok_out after reset", tok_out, 1);
                    // load kill mask
                    mask_in = kl[0];
                    #1 mask_clk = 1'b1;
                    #1 mask_clk = 1'b0;
                    chk("R5 mask_out", mask_out, kl);
                    // acquisition
                    acq = 1'b1; tok_in = 1'b0;
                    for (int i = 0; i < nh; i++) begin
                        @(negedge clk);
                        ts_bus = stamp(base, i);
                        hit = 1'b1;
                        if (i < 2) exp_ts[i] = stamp(base, i);
                        @(negedge clk);
                        hit = 1'b0;
                        ts_bus = stamp(base, i) + 5'd1;
                    end
                    #1;
                    chk("R10 no select in acquisition", row_sel, 0);
                    chk("R7 tok_out low without token", tok_out, 0);
                    if (wp != 0) begin
                        @(negedge clk); rst = 1'b1;
                        @(negedge clk); rst = 1'b0;
                        #1;
                        chk("R5 mask kept over reset", mask_out, kl);
                    end
                    // readout with stray hit (R6)
                    @(negedge clk);
                    acq = 1'b0; hit = 1'b1; ts_bus = 5'h1f; tok_in = 1'b0;
                    @(negedge clk);
                    hit = 1'b0;
                    nexp = (kl != 0 || wp != 0) ? 0 : (nh > 2 ? 2 : nh);
                    #1;
                    chk("R10 no select without token", row_sel, 0);
                    tok_in = 1'b1;
                    #1;
                    chk("R7/R9 tok_out on token arrival", tok_out, (nexp == 0) ? 1 : 0);
                    for (int k = 0; k < nexp; k++) begin
                        @(negedge clk);
                        #1;
                        chk("R8 row_sel during read", row_sel, 1);
                        chk("R8 col_sel during read", col_sel, 1);
                        chk(k == 0 ? "R2 first stamp" : "R3 second stamp", ts_out, exp_ts[k]);
                        chk("R9 token release timing", tok_out, (k == nexp - 1) ? 1 : 0);
                        if (k == 0 && nexp == 2) begin
                            tok_in = 1'b0;
                            @(negedge clk);
                            #1;
                            chk("R10 paused row_sel", row_sel, 0);
                            chk("R10 paused ts_out", ts_out, 0);
                            chk("R9 paused tok_out", tok_out, 0);
                            tok_in = 1'b1;
                        end
                    end
                    @(negedge clk);
                    #1;
                    chk("R4/R6 no extra read", row_sel, 0);
                    chk("R10 bus idle after read", ts_out, 0);
                    chk("R9 token passed after read", tok_out, 1);
                    @(negedge clk);
                    #1;
                    chk("R4/R6 still idle", row_sel, 0);
                end
            end
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog (all) actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule